// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block keeps the event flags and the interrupt enables of a serial bus controller and drives a single level interrupt line plus a receive and a transmit DMA request line. The transfer logic raises individual flags through one-cycle set pulses. Software reaches the block through a small register port to program enables and DMA routing, to inspect flags, and to acknowledge events.

The acknowledge scheme depends on a build-time revision parameter. In the legacy revision, reading the vector register returns the 1-based number of the lowest pending enabled flag and clears that flag. Software can therefore service sources in fixed priority order, with one read per source. In the newer revision the vector register has no function. Software instead clears flags by writing ones to the status register, and a test register can force the low six flags high. Routing a ready flag to DMA removes the matching interrupt enable, so the CPU does not also see that event.

Top module: `ivc_irq_vector`

Register addresses on `reg_addr_i`: 0 enable, 1 status, 2 vector, 3 DMA control, 4 force. Any other address reads as 0 and ignores writes. `reg_rdata_o` is registered. It changes only on the clock edge that samples `reg_rd_i` and otherwise holds its value.

## Requirements
- R1: `irq_o` is high exactly when (status AND enable) is nonzero, judged on the register values after the same clock edge. A flag whose enable bit is 0 does not raise `irq_o`.
- R2: In the legacy revision (NEW_REV=0), a read of address 2 returns the 1-based position of the lowest set bit of (status AND enable), or 0 when that AND is zero.
- R3: In the legacy revision, the read in R2 clears that one status bit at the same edge that returns the data. All other status bits are unchanged.
- R4: In the newer revision (NEW_REV=1), a read of address 2 returns 0 and changes no status bit.
- R5: A write to address 3 keeps only bits 15 and 7 of the data, and those bits read back at address 3. Writing bit 15 as 1 clears enable bit 3. Writing bit 7 as 1 clears enable bit 4.
- R6: `dma_rx_req_o` equals status bit 3 AND DMA-control bit 15. `dma_tx_req_o` equals status bit 4 AND DMA-control bit 7.
- R7: A write to address 0 stores the data masked to 0x001F in the legacy revision and to 0x003F in the newer one. The result reads back at address 0.
- R8: In the newer revision, a write to address 1 clears the status bits where the data is 1, limited to mask 0x0027. In the legacy revision, a write to address 1 has no effect.
- R9: In the newer revision, a write to address 4 with data bit 11 set forces status bits 0 to 5 to 1. A write without bit 11 does nothing. In the legacy revision, writes to address 4 do nothing.
- R10: A read of address 1 returns the status register OR'ed with `bus_busy_i` in bit 12.
- R11: When a set pulse and a clear (vector read or write-one-to-clear) hit the same status bit in one cycle, the bit ends up set.
- R12: After reset, status, enable, DMA control, `reg_rdata_o` and all three request outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_i | input | DW | One-cycle set pulses, one per status bit |
| bus_busy_i | input | 1 | Bus busy indication, reported in status reads |
| reg_addr_i | input | AW | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_wdata_i | input | DW | Write data |
| reg_rdata_o | output | DW | Registered read data |
| irq_o | output | 1 | Interrupt request, level |
| dma_rx_req_o | output | 1 | Receive DMA request |
| dma_tx_req_o | output | 1 | Transmit DMA request |

## Verification
The bench drives one instance of each revision with the same stimulus and checks both against a behavioural model on every cycle.

The stimulus reads the vector register repeatedly with two sources pending. A priority encoder that picks the highest bit, or that returns a 0-based index, gives the wrong sequence. A clear aimed at the wrong bit leaves the interrupt line stuck. The stimulus also collides a set pulse with a vector acknowledge, and with a write-one-to-clear, on the same bit; a design where the clear wins drops the event.

Write-one-to-clear data with bits outside mask 0x27 shows whether the ready flags are cleared by mistake. A DMA-control write shows whether the enable bits are left untouched. Reads on the legacy instance show whether it wrongly accepts status and force writes.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  typedef enum logic [2:0] {
    IVC_A_EN    = 3'd0,
    IVC_A_STAT  = 3'd1,
    IVC_A_VEC   = 3'd2,
    IVC_A_DMA   = 3'd3,
    IVC_A_FORCE = 3'd4
  } ivc_addr_e;
endpackage

// File: rtl/ivc_lowest_set.sv
module ivc_lowest_set #(
  parameter int W  = 16,
  localparam int IW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o
);
  // 1-based index of the lowest set bit; 0 when none is set.
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i + 1);
    end
  end
endmodule

// File: rtl/ivc_status_bank.sv
module ivc_status_bank #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_d,
  output logic [W-1:0] stat_q
);
  for (genvar k = 0; k < W; k++) begin : g_bit
    // set has priority over clear
    assign stat_d[k] = set_i[k] | (stat_q[k] & ~clr_i[k]);

    always_ff @(posedge clk) begin
      if (rst) stat_q[k] <= 1'b0;
      else     stat_q[k] <= stat_d[k];
    end

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (rst)
      set_i[k] |=> stat_q[k]);
    assert_clear_only_R3: assert property (@(posedge clk) disable iff (rst)
      (clr_i[k] && !set_i[k]) |=> !stat_q[k]);
  end
endmodule

// File: rtl/ivc_irq_vector.sv
module ivc_irq_vector #(
  parameter bit NEW_REV       = 1'b0,
  parameter int DW            = 16,
  parameter int AW            = 3,
  parameter int EN_BITS_OLD   = 5,
  parameter int EN_BITS_NEW   = 6,
  parameter int RX_BIT        = 3,
  parameter int TX_BIT        = 4,
  parameter int BUSY_BIT      = 12,
  parameter int DMA_RX_EN_BIT = 15,
  parameter int DMA_TX_EN_BIT = 7,
  parameter int FORCE_TRIG    = 11,
  parameter int FORCE_BITS    = 6,
  parameter logic [DW-1:0] W1C_MASK = 16'h0027
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] set_i,
  input  logic          bus_busy_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          irq_o,
  output logic          dma_rx_req_o,
  output logic          dma_tx_req_o
);
  import ivc_pkg::*;

  localparam int IW = $clog2(DW + 1);
  localparam int EN_BITS = NEW_REV ? EN_BITS_NEW : EN_BITS_OLD;
  localparam logic [DW-1:0] ONE        = DW'(1);
  localparam logic [DW-1:0] EN_MASK    = DW'((1 << EN_BITS) - 1);
  localparam logic [DW-1:0] FORCE_MASK = DW'((1 << FORCE_BITS) - 1);
  localparam logic [DW-1:0] DMA_MASK   = (ONE << DMA_RX_EN_BIT) | (ONE << DMA_TX_EN_BIT);

  logic [DW-1:0] en_q, en_d, dma_q, dma_d;
  logic [DW-1:0] stat_q, stat_d, pend;
  logic [DW-1:0] clr_vec, clr_w1c, force_set;
  logic [IW-1:0] vec_idx;
  logic          sel_en, sel_stat, sel_vec, sel_dma, sel_force, vec_ack;
  logic [DW-1:0] rdata_d;

  assign sel_en    = reg_addr_i == AW'(IVC_A_EN);
  assign sel_stat  = reg_addr_i == AW'(IVC_A_STAT);
  assign sel_vec   = reg_addr_i == AW'(IVC_A_VEC);
  assign sel_dma   = reg_addr_i == AW'(IVC_A_DMA);
  assign sel_force = reg_addr_i == AW'(IVC_A_FORCE);

  assign pend = stat_q & en_q;

  ivc_lowest_set #(.W(DW)) u_prio (
    .vec_i (pend),
    .idx_o (vec_idx)
  );

  // acknowledge paths, chosen by revision
  generate
    if (NEW_REV) begin : g_new_ack
      assign vec_ack   = 1'b0;
      assign clr_vec   = '0;
      assign clr_w1c   = (reg_wr_i && sel_stat) ? (reg_wdata_i & W1C_MASK) : '0;
      assign force_set = (reg_wr_i && sel_force && reg_wdata_i[FORCE_TRIG]) ? FORCE_MASK : '0;
    end else begin : g_old_ack
      assign vec_ack   = reg_rd_i && sel_vec && (vec_idx != '0);
      assign clr_vec   = vec_ack ? (ONE << (vec_idx - 1'b1)) : '0;
      assign clr_w1c   = '0;
      assign force_set = '0;
    end
  endgenerate

  ivc_status_bank #(.W(DW)) u_stat (
    .clk    (clk),
    .rst    (rst),
    .set_i  (set_i | force_set),
    .clr_i  (clr_vec | clr_w1c),
    .stat_d (stat_d),
    .stat_q (stat_q)
  );

  // enable and DMA-control next state
  always_comb begin
    en_d  = en_q;
    dma_d = dma_q;
    if (reg_wr_i && sel_en) begin
      en_d = reg_wdata_i & EN_MASK;
    end else if (reg_wr_i && sel_dma) begin
      dma_d = reg_wdata_i & DMA_MASK;
      if (reg_wdata_i[DMA_RX_EN_BIT]) en_d[RX_BIT] = 1'b0;
      if (reg_wdata_i[DMA_TX_EN_BIT]) en_d[TX_BIT] = 1'b0;
    end
  end

  // read mux, sampled from pre-edge state
  always_comb begin
    rdata_d = '0;
    unique case (1'b1)
      sel_en:   rdata_d = en_q;
      sel_stat: rdata_d = stat_q | (DW'(bus_busy_i) << BUSY_BIT);
      sel_vec:  rdata_d = NEW_REV ? '0 : {{(DW-IW){1'b0}}, vec_idx};
      sel_dma:  rdata_d = dma_q;
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q         <= '0;
      dma_q        <= '0;
      reg_rdata_o  <= '0;
      irq_o        <= 1'b0;
      dma_rx_req_o <= 1'b0;
      dma_tx_req_o <= 1'b0;
    end else begin
      en_q         <= en_d;
      dma_q        <= dma_d;
      if (reg_rd_i) reg_rdata_o <= rdata_d;
      irq_o        <= |(stat_d & en_d);
      dma_rx_req_o <= dma_d[DMA_RX_EN_BIT] & stat_d[RX_BIT];
      dma_tx_req_o <= dma_d[DMA_TX_EN_BIT] & stat_d[TX_BIT];
    end
  end

  assert_irq_level_R1: assert property (@(posedge clk) disable iff (rst)
    irq_o == (|(stat_q & en_q)));
  assert_dma_rx_R6: assert property (@(posedge clk) disable iff (rst)
    dma_rx_req_o == (dma_q[DMA_RX_EN_BIT] && stat_q[RX_BIT]));
  assert_dma_tx_R6: assert property (@(posedge clk) disable iff (rst)
    dma_tx_req_o == (dma_q[DMA_TX_EN_BIT] && stat_q[TX_BIT]));
  assert_dma_kills_en_R5: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_i && sel_dma && reg_wdata_i[DMA_RX_EN_BIT]) |=> !en_q[RX_BIT]);
  assert_en_mask_R7: assert property (@(posedge clk) disable iff (rst)
    (en_q & ~EN_MASK) == '0);
  assert_vec_one_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (vec_ack && set_i == '0) |=> $countones(stat_q) == $countones($past(stat_q)) - 1);
  assert_vec_dead_R4: assert property (@(posedge clk) disable iff (rst)
    (NEW_REV && reg_rd_i && sel_vec) |=> reg_rdata_o == '0);
endmodule

// File: tb/ivc_irq_vector_tb.sv
`timescale 1ns/1ps
module ivc_irq_vector_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] set_in = '0;
  logic        busy = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [15:0] wdata = '0;

  logic [15:0] rdata [2];
  logic        irq [2], rxq [2], txq [2];

  int checks = 0, errors = 0;
  string tag = "R12";
  bit running = 1'b0;

  always #4 clk = ~clk;

  ivc_irq_vector #(.NEW_REV(1'b0)) u_dut (
    .clk(clk), .rst(rst), .set_i(set_in), .bus_busy_i(busy),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata[0]), .irq_o(irq[0]), .dma_rx_req_o(rxq[0]), .dma_tx_req_o(txq[0]));

  ivc_irq_vector #(.NEW_REV(1'b1)) u_dut_new (
    .clk(clk), .rst(rst), .set_i(set_in), .bus_busy_i(busy),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata[1]), .irq_o(irq[1]), .dma_rx_req_o(rxq[1]), .dma_tx_req_o(txq[1]));

  // behavioural reference model, one per revision
  logic [15:0] m_stat [2], m_en [2], m_dma [2], m_rdata [2];
  logic        m_irq [2], m_rx [2], m_tx [2];

  always @(posedge clk) begin
    for (int r = 0; r < 2; r++) begin
      logic [15:0] pend, clr, setv;
      int vec;
      if (rst) begin
        m_stat[r] = 0; m_en[r] = 0; m_dma[r] = 0; m_rdata[r] = 0;
        m_irq[r] = 0; m_rx[r] = 0; m_tx[r] = 0;
      end else begin
        pend = m_stat[r] & m_en[r];
        vec = 0;
        for (int i = 15; i >= 0; i--) if (pend[i]) vec = i + 1;
        if (rd) begin
          case (addr)
            3'd0: m_rdata[r] = m_en[r];
            3'd1: m_rdata[r] = m_stat[r] | (busy ? 16'h1000 : 16'h0000);
            3'd2: m_rdata[r] = (r == 1) ? 16'h0 : 16'(vec);
            3'd3: m_rdata[r] = m_dma[r];
            default: m_rdata[r] = 0;
          endcase
        end
        clr = 0;
        setv = set_in;
        if (r == 0 && rd && addr == 3'd2 && vec != 0) clr[vec-1] = 1'b1;
        if (r == 1 && wr && addr == 3'd1) clr = wdata & 16'h0027;
        if (r == 1 && wr && addr == 3'd4 && wdata[11]) setv = setv | 16'h003f;
        if (wr && addr == 3'd0) m_en[r] = wdata & ((r == 1) ? 16'h003f : 16'h001f);
        if (wr && addr == 3'd3) begin
          m_dma[r] = wdata & 16'h8080;
          if (wdata[15]) m_en[r][3] = 1'b0;
          if (wdata[7])  m_en[r][4] = 1'b0;
        end
        m_stat[r] = (m_stat[r] & ~clr) | setv;
        m_irq[r] = |(m_stat[r] & m_en[r]);
        m_rx[r] = m_dma[r][15] & m_stat[r][3];
        m_tx[r] = m_dma[r][7] & m_stat[r][4];
      end
    end
  end

  task automatic chk(string t, string what, int r, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL [%s] rev%0d %s actual=%h expected=%h", t, r, what, act, exp);
    end
  endtask

  // compare outputs against the model away from the active edge
  always @(negedge clk) begin
    if (running) begin
      for (int r = 0; r < 2; r++) begin
        chk((tag == "R6") ? "R6" : tag, "irq_o", r, 16'(irq[r]), 16'(m_irq[r]));
        chk("R6", "dma_rx_req_o", r, 16'(rxq[r]), 16'(m_rx[r]));
        chk("R6", "dma_tx_req_o", r, 16'(txq[r]), 16'(m_tx[r]));
        chk(tag, "reg_rdata_o", r, rdata[r], m_rdata[r]);
      end
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_wr(logic [2:0] a, logic [15:0] d);
    addr = a; wdata = d; wr = 1'b1; step(); wr = 1'b0;
  endtask

  task automatic do_rd(logic [2:0] a);
    addr = a; rd = 1'b1; step(); rd = 1'b0;
  endtask

  task automatic pulse(logic [15:0] s);
    set_in = s; step(); set_in = '0;
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    // R12 reset state
    for (int r = 0; r < 2; r++) begin
      chk("R12", "reset rdata", r, rdata[r], 16'h0);
      chk("R12", "reset irq", r, 16'(irq[r]), 16'h0);
      chk("R12", "reset dma", r, 16'({rxq[r], txq[r]}), 16'h0);
    end
    running = 1'b1;

    tag = "R7";  do_wr(3'd0, 16'hffff); do_rd(3'd0);
    tag = "R1";  pulse(16'h0012); step(); pulse(16'h0200); step();
    tag = "R2";  do_rd(3'd2); do_rd(3'd2);
    tag = "R3";  do_rd(3'd1); do_rd(3'd2); do_rd(3'd1);
    tag = "R4";  pulse(16'h0012); do_rd(3'd2); do_rd(3'd1);
    tag = "R10"; busy = 1'b1; do_rd(3'd1); busy = 1'b0; do_rd(3'd1);
    tag = "R8";  do_wr(3'd1, 16'hffff); do_rd(3'd1);
    tag = "R9";  do_wr(3'd4, 16'h07ff); do_rd(3'd1); do_wr(3'd4, 16'h0800); do_rd(3'd1);
    tag = "R11"; pulse(16'h0001);
    addr = 3'd2; rd = 1'b1; set_in = 16'h0001; step(); rd = 1'b0; set_in = '0;
    do_rd(3'd1);
    addr = 3'd1; wr = 1'b1; wdata = 16'h0001; set_in = 16'h0001; step(); wr = 1'b0; set_in = '0;
    do_rd(3'd1);
    tag = "R5";  do_wr(3'd0, 16'h003f); do_wr(3'd3, 16'hffff); do_rd(3'd3); do_rd(3'd0);
    tag = "R6";  pulse(16'h0018); step(); do_wr(3'd3, 16'h0080); step();
    do_wr(3'd3, 16'h0000); step();
    tag = "R1";  do_wr(3'd0, 16'h0000); step(); do_wr(3'd0, 16'h0020); step();
    tag = "R2";  for (int k = 0; k < 8; k++) do_rd(3'd2);
    do_wr(3'd0, 16'h0000); do_rd(3'd2); do_rd(3'd6);
    step();
    running = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL [watchdog] run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule